// File: doc/BRIEF.md
# Multi-Sequencer ADC Sample FIFO

This block is the digital side of an analog-to-digital converter with four sample sequencers. Each sequencer has an enable bit, a four-bit trigger-source field and a private 16-entry result queue. When a timer pulse reaches `trig_i`, every enabled sequencer whose source field selects the timer takes one sample, pushes it into its queue and raises its raw interrupt bit. A 32-bit linear congruential generator produces the sample values in place of a real converter.

Software reaches the block through a simple register port. Writes take effect on the clock edge. Reads are combinational from the current state. A read of a sequencer's pop register takes the oldest entry and advances the queue on that edge. Each queue publishes its pointers and its empty and full flags in one status word. Sticky overflow and underflow bits record pushes that were dropped and pops that found nothing.

Top module: `adc_seq_top`

## Requirements
- R1: After reset every queue status word reads 0x100, all other registers read 0, the generator state is 0 and `irq_o` is 0.
- R2: A queue status word carries the read index in bits 3:0, the write index in bits 7:4, empty in bit 8 and full in bit 12. All other bits are 0.
- R3: A push stores the sample at the write index, advances that index modulo 16 and clears empty. It sets full when the write index reaches the read index. A push to a full queue is dropped.
- R4: A read of the pop register (window offset 0x8) returns the entry at the read index. It then advances that index modulo 16, clears full, and sets empty when the read index reaches the write index. On an empty queue the pop returns the entry and leaves the queue unchanged.
- R5: On a cycle with `trig_i` high, sequencer n samples only if enable bit n (offset 0x00) is set and its source field (offset 0x14, bits 4n+3:4n) equals 5.
- R6: Sequencers that sample in one cycle are served in ascending index order. Each sample first sets the state to state*314159+1 (mod 2^32) and then pushes 0x200 plus bits 18:16 of the new state.
- R7: A sample on sequencer n sets raw bit n (offset 0x04, read-only). The mask lives at offset 0x08. `irq_o[n]` is raw AND mask, and offset 0x0C reads raw AND mask.
- R8: Writing ones to offset 0x0C clears those raw bits. A sample in the same cycle wins over the clear.
- R9: A push dropped by a full queue sets bit n at offset 0x10. An empty pop sets bit n at offset 0x18. Both bits are sticky, are cleared by writing one, and a new event wins over a clear in the same cycle.
- R10: Sequencer n's registers sit at 0x40+32n: mux at +0x0 (keeps only bits 0x33333333), control at +0x4 (keeps all 32 bits), pop at +0x8, status at +0xC. The enable register keeps only its low 4 bits. Unmapped offsets read 0 and ignore writes.
- R11: If a pop and a push reach the same queue in one cycle, the pop acts on the old state and the push acts on the state the pop left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Timer trigger pulse, one cycle per conversion event |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (pops when aimed at a pop register) |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from state and `addr_i` |
| irq_o | output | 4 | Per-sequencer interrupt, raw AND mask |

## Verification
Read data depends only on state and address, so the bench drives the address at a falling edge and samples `rdata_o` 1 ns later, in the same cycle. Writes, pops and trigger pushes change state on the next rising edge. Their results, including `irq_o`, are compared at the falling edge that follows. A behavioural reference model steps on every rising edge, and `irq_o` is compared against it at every falling edge. Fixed expected values are also written out for the reset state, for the first two generator samples (0x200 and 0x204), for the full and empty status words and for the same-cycle pop and push cases.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
    localparam int NUM_SEQ  = 4;
    localparam int DEPTH    = 16;
    localparam int SAMPLE_W = 10;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int LCG_W    = 32;
    localparam int SEL_W    = 4;

    localparam logic [SEL_W-1:0] SEL_TIMER   = 4'd5;
    localparam logic [LCG_W-1:0] LCG_MULT    = 32'd314159;
    localparam logic [LCG_W-1:0] LCG_INC     = 32'd1;
    localparam int               SAMPLE_LSB  = 16;
    localparam int               SAMPLE_BITS = 3;
    localparam logic [DATA_W-1:0] SAMPLE_BASE = 32'h0000_0200;
    localparam logic [DATA_W-1:0] MUX_KEEP    = 32'h3333_3333;

    // status word layout
    localparam int STAT_WR_LSB    = 4;
    localparam int STAT_EMPTY_BIT = 8;
    localparam int STAT_FULL_BIT  = 12;

    // global register offsets
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MSTAT  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_OVF    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_SRCSEL = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_UNF    = 8'h18;

    // per-sequencer windows
    localparam logic [ADDR_W-1:0] WIN_BASE  = 8'h40;
    localparam int                WIN_SHIFT = 5;
    localparam logic [WIN_SHIFT-1:0] SUB_MUX  = 5'h00;
    localparam logic [WIN_SHIFT-1:0] SUB_CTL  = 5'h04;
    localparam logic [WIN_SHIFT-1:0] SUB_POP  = 5'h08;
    localparam logic [WIN_SHIFT-1:0] SUB_STAT = 5'h0C;

    typedef enum logic [2:0] {
        WREG_NONE,
        WREG_MUX,
        WREG_CTL,
        WREG_POP,
        WREG_STAT
    } win_reg_e;
endpackage

// File: rtl/adc_seq_fifo.sv
`timescale 1ns/1ps
module adc_seq_fifo
    import adc_seq_pkg::*;
#(
    parameter int DEPTH_P    = DEPTH,
    parameter int SAMPLE_W_P = SAMPLE_W,
    parameter int DATA_W_P   = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_i,
    input  logic [SAMPLE_W_P-1:0] push_data_i,
    input  logic                  pop_i,
    output logic [SAMPLE_W_P-1:0] rd_data_o,
    output logic [DATA_W_P-1:0]   status_o,
    output logic                  ovf_o,
    output logic                  unf_o
);
    localparam int PTR_W = $clog2(DEPTH_P);

    typedef struct packed {
        logic [DEPTH_P-1:0][SAMPLE_W_P-1:0] mem;
        logic [PTR_W-1:0]                   rd;
        logic [PTR_W-1:0]                   wr;
        logic                               empty;
        logic                               full;
    } fifo_t;

    fifo_t st_d, st_q;

    // pop acts on the old state, push acts on what the pop left
    always_comb begin
        st_d  = st_q;
        ovf_o = 1'b0;
        unf_o = 1'b0;
        if (pop_i) begin
            if (st_q.empty) begin
                unf_o = 1'b1;
            end else begin
                st_d.rd   = st_q.rd + 1'b1;
                st_d.full = 1'b0;
                if (st_d.rd == st_q.wr) begin
                    st_d.empty = 1'b1;
                end
            end
        end
        if (push_i) begin
            if (st_d.full) begin
                ovf_o = 1'b1;
            end else begin
                st_d.mem[st_d.wr] = push_data_i;
                st_d.wr           = st_d.wr + 1'b1;
                st_d.empty        = 1'b0;
                if (st_d.wr == st_d.rd) begin
                    st_d.full = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.mem[st_q.rd];

    always_comb begin
        status_o                           = '0;
        status_o[PTR_W-1:0]                = st_q.rd;
        status_o[STAT_WR_LSB +: PTR_W]     = st_q.wr;
        status_o[STAT_EMPTY_BIT]           = st_q.empty;
        status_o[STAT_FULL_BIT]            = st_q.full;
    end
endmodule

// File: rtl/adc_seq_lcg.sv
`timescale 1ns/1ps
module adc_seq_lcg
    import adc_seq_pkg::*;
#(
    parameter int N_P        = NUM_SEQ,
    parameter int W_P        = LCG_W,
    parameter int SAMPLE_W_P = SAMPLE_W
) (
    input  logic [W_P-1:0]                  seed_i,
    input  logic [N_P-1:0]                  take_i,
    output logic [W_P-1:0]                  seed_o,
    output logic [N_P-1:0][SAMPLE_W_P-1:0]  sample_o
);
    logic [N_P:0][W_P-1:0] chain;

    assign chain[0] = seed_i;

    // one generator step per sampling sequencer, lowest index first
    for (genvar g = 0; g < N_P; g++) begin : g_stage
        logic [W_P-1:0] stepped;
        assign stepped      = chain[g] * W_P'(LCG_MULT) + W_P'(LCG_INC);
        assign chain[g+1]   = take_i[g] ? stepped : chain[g];
        assign sample_o[g]  = SAMPLE_W_P'(SAMPLE_BASE)
                            + SAMPLE_W_P'(stepped[SAMPLE_LSB +: SAMPLE_BITS]);
    end

    assign seed_o = chain[N_P];
endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int NUM_SEQ_P  = NUM_SEQ,
    parameter int DEPTH_P    = DEPTH,
    parameter int SAMPLE_W_P = SAMPLE_W,
    parameter int ADDR_W_P   = ADDR_W,
    parameter int DATA_W_P   = DATA_W,
    parameter int LCG_W_P    = LCG_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig_i,
    input  logic                  wr_en_i,
    input  logic                  rd_en_i,
    input  logic [ADDR_W_P-1:0]   addr_i,
    input  logic [DATA_W_P-1:0]   wdata_i,
    output logic [DATA_W_P-1:0]   rdata_o,
    output logic [NUM_SEQ_P-1:0]  irq_o
);
    localparam int IDX_W   = (NUM_SEQ_P > 1) ? $clog2(NUM_SEQ_P) : 1;
    localparam int WIN_SPAN = NUM_SEQ_P << WIN_SHIFT;

    typedef struct packed {
        logic [NUM_SEQ_P-1:0]                 enable;
        logic [NUM_SEQ_P-1:0]                 raw;
        logic [NUM_SEQ_P-1:0]                 mask;
        logic [NUM_SEQ_P-1:0]                 ovf;
        logic [NUM_SEQ_P-1:0]                 unf;
        logic [NUM_SEQ_P-1:0][SEL_W-1:0]      srcsel;
        logic [NUM_SEQ_P-1:0][DATA_W_P-1:0]   smux;
        logic [NUM_SEQ_P-1:0][DATA_W_P-1:0]   sctl;
        logic [LCG_W_P-1:0]                   lcg;
    } regs_t;

    regs_t st_d, st_q;

    // ---------------- address decode ----------------
    logic [ADDR_W_P-1:0]  win_off;
    logic                 in_win;
    logic [IDX_W-1:0]     win_idx;
    logic [WIN_SHIFT-1:0] win_sub;
    win_reg_e             win_reg;

    always_comb begin
        win_off = addr_i - ADDR_W_P'(WIN_BASE);
        in_win  = (addr_i >= ADDR_W_P'(WIN_BASE)) && (win_off < ADDR_W_P'(WIN_SPAN));
        win_idx = win_off[WIN_SHIFT +: IDX_W];
        win_sub = win_off[WIN_SHIFT-1:0];
        win_reg = WREG_NONE;
        if (in_win) begin
            case (win_sub)
                SUB_MUX:  win_reg = WREG_MUX;
                SUB_CTL:  win_reg = WREG_CTL;
                SUB_POP:  win_reg = WREG_POP;
                SUB_STAT: win_reg = WREG_STAT;
                default:  win_reg = WREG_NONE;
            endcase
        end
    end

    // ---------------- trigger qualification and pops ----------------
    logic [NUM_SEQ_P-1:0] take_vec;
    logic [NUM_SEQ_P-1:0] pop_vec;

    for (genvar g = 0; g < NUM_SEQ_P; g++) begin : g_qual
        assign take_vec[g] = trig_i && st_q.enable[g] && (st_q.srcsel[g] == SEL_TIMER);
        assign pop_vec[g]  = rd_en_i && (win_reg == WREG_POP) && (win_idx == IDX_W'(g));
    end

    // ---------------- sample generator ----------------
    logic [LCG_W_P-1:0]                   lcg_next;
    logic [NUM_SEQ_P-1:0][SAMPLE_W_P-1:0] samples;

    adc_seq_lcg #(
        .N_P        (NUM_SEQ_P),
        .W_P        (LCG_W_P),
        .SAMPLE_W_P (SAMPLE_W_P)
    ) u_lcg (
        .seed_i   (st_q.lcg),
        .take_i   (take_vec),
        .seed_o   (lcg_next),
        .sample_o (samples)
    );

    // ---------------- result queues ----------------
    logic [NUM_SEQ_P-1:0][SAMPLE_W_P-1:0] fifo_rd;
    logic [NUM_SEQ_P-1:0][DATA_W_P-1:0]   fifo_stat;
    logic [NUM_SEQ_P-1:0]                 ovf_evt;
    logic [NUM_SEQ_P-1:0]                 unf_evt;

    for (genvar g = 0; g < NUM_SEQ_P; g++) begin : g_seq
        adc_seq_fifo #(
            .DEPTH_P    (DEPTH_P),
            .SAMPLE_W_P (SAMPLE_W_P),
            .DATA_W_P   (DATA_W_P)
        ) u_fifo (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (take_vec[g]),
            .push_data_i (samples[g]),
            .pop_i       (pop_vec[g]),
            .rd_data_o   (fifo_rd[g]),
            .status_o    (fifo_stat[g]),
            .ovf_o       (ovf_evt[g]),
            .unf_o       (unf_evt[g])
        );
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d     = st_q;
        st_d.lcg = lcg_next;
        if (wr_en_i) begin
            if (in_win) begin
                case (win_reg)
                    WREG_MUX: st_d.smux[win_idx] = wdata_i & DATA_W_P'(MUX_KEEP);
                    WREG_CTL: st_d.sctl[win_idx] = wdata_i;
                    default:  ;
                endcase
            end else begin
                case (addr_i)
                    ADDR_W_P'(OFS_ENABLE): st_d.enable = wdata_i[NUM_SEQ_P-1:0];
                    ADDR_W_P'(OFS_MASK):   st_d.mask   = wdata_i[NUM_SEQ_P-1:0];
                    ADDR_W_P'(OFS_MSTAT):  st_d.raw    = st_q.raw & ~wdata_i[NUM_SEQ_P-1:0];
                    ADDR_W_P'(OFS_OVF):    st_d.ovf    = st_q.ovf & ~wdata_i[NUM_SEQ_P-1:0];
                    ADDR_W_P'(OFS_UNF):    st_d.unf    = st_q.unf & ~wdata_i[NUM_SEQ_P-1:0];
                    ADDR_W_P'(OFS_SRCSEL): st_d.srcsel = wdata_i[NUM_SEQ_P*SEL_W-1:0];
                    default: ;
                endcase
            end
        end
        // events win over clears
        st_d.raw = st_d.raw | take_vec;
        st_d.ovf = st_d.ovf | ovf_evt;
        st_d.unf = st_d.unf | unf_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- read path ----------------
    always_comb begin
        rdata_o = '0;
        if (in_win) begin
            case (win_reg)
                WREG_MUX:  rdata_o = st_q.smux[win_idx];
                WREG_CTL:  rdata_o = st_q.sctl[win_idx];
                WREG_POP:  rdata_o = DATA_W_P'(fifo_rd[win_idx]);
                WREG_STAT: rdata_o = fifo_stat[win_idx];
                default:   rdata_o = '0;
            endcase
        end else begin
            case (addr_i)
                ADDR_W_P'(OFS_ENABLE): rdata_o = DATA_W_P'(st_q.enable);
                ADDR_W_P'(OFS_RAW):    rdata_o = DATA_W_P'(st_q.raw);
                ADDR_W_P'(OFS_MASK):   rdata_o = DATA_W_P'(st_q.mask);
                ADDR_W_P'(OFS_MSTAT):  rdata_o = DATA_W_P'(st_q.raw & st_q.mask);
                ADDR_W_P'(OFS_OVF):    rdata_o = DATA_W_P'(st_q.ovf);
                ADDR_W_P'(OFS_UNF):    rdata_o = DATA_W_P'(st_q.unf);
                ADDR_W_P'(OFS_SRCSEL): rdata_o = DATA_W_P'(st_q.srcsel);
                default:               rdata_o = '0;
            endcase
        end
    end

    assign irq_o = st_q.raw & st_q.mask;

    logic [NUM_SEQ_P-1:0] unf_flags;
    assign unf_flags = st_q.unf;
endmodule

// File: rtl/adc_seq_checker.sv
`timescale 1ns/1ps
module adc_seq_checker
    import adc_seq_pkg::*;
#(
    parameter int NUM_SEQ_P = NUM_SEQ,
    parameter int DEPTH_P   = DEPTH,
    parameter int ADDR_W_P  = ADDR_W,
    parameter int DATA_W_P  = DATA_W
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                wr_en_i,
    input logic [ADDR_W_P-1:0]                 addr_i,
    input logic [NUM_SEQ_P-1:0]                wdata_i,
    input logic [NUM_SEQ_P-1:0]                irq_o,
    input logic [NUM_SEQ_P-1:0][DATA_W_P-1:0]  stat_i,
    input logic [NUM_SEQ_P-1:0]                pop_i,
    input logic [NUM_SEQ_P-1:0]                push_i,
    input logic [NUM_SEQ_P-1:0]                unf_i
);
    localparam int PTR_W = $clog2(DEPTH_P);

    // R1: first cycle out of reset has no interrupt
    assert_irq_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_o == '0));

    for (genvar g = 0; g < NUM_SEQ_P; g++) begin : g_chk
        // R2: empty and full never together
        assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(stat_i[g][STAT_EMPTY_BIT] && stat_i[g][STAT_FULL_BIT]));

        // R2: either flag implies equal indices
        assert_flag_ptrs_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_i[g][STAT_EMPTY_BIT] || stat_i[g][STAT_FULL_BIT])
            |-> (stat_i[g][PTR_W-1:0] == stat_i[g][STAT_WR_LSB +: PTR_W]));

        // R3: only a pop can leave the full state
        assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_i[g][STAT_FULL_BIT] && !pop_i[g]) |=> stat_i[g][STAT_FULL_BIT]);

        // R4: only a push can leave the empty state
        assert_empty_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_i[g][STAT_EMPTY_BIT] && !push_i[g]) |=> stat_i[g][STAT_EMPTY_BIT]);

        // R9: underflow bit is sticky until written with one
        assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (unf_i[g] && !(wr_en_i && addr_i == ADDR_W_P'(OFS_UNF) && wdata_i[g]))
            |=> unf_i[g]);
    end
endmodule

bind adc_seq_top adc_seq_checker #(
    .NUM_SEQ_P (NUM_SEQ_P),
    .DEPTH_P   (DEPTH_P),
    .ADDR_W_P  (ADDR_W_P),
    .DATA_W_P  (DATA_W_P)
) u_adc_seq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i[NUM_SEQ_P-1:0]),
    .irq_o   (irq_o),
    .stat_i  (fifo_stat),
    .pop_i   (pop_vec),
    .push_i  (take_vec),
    .unf_i   (unf_flags)
);

// File: tb/adc_seq_top_bench.sv
`timescale 1ns/1ps
module adc_seq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #5 clk = ~clk;

    adc_seq_top u_adc_seq_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    // ---------------- reference model ----------------
    logic [3:0]  m_enable, m_raw, m_mask, m_ovf, m_unf;
    logic [15:0] m_src;
    logic [31:0] m_smux [4];
    logic [31:0] m_sctl [4];
    logic [31:0] m_noise;
    logic [9:0]  m_mem [4][16];
    int          m_rd [4];
    int          m_wr [4];
    bit          m_empty [4];
    bit          m_full [4];

    task automatic model_reset();
        m_enable = 0; m_raw = 0; m_mask = 0; m_ovf = 0; m_unf = 0;
        m_src = 0; m_noise = 0;
        for (int s = 0; s < 4; s++) begin
            m_smux[s] = 0; m_sctl[s] = 0;
            m_rd[s] = 0; m_wr[s] = 0; m_empty[s] = 1; m_full[s] = 0;
            for (int e = 0; e < 16; e++) m_mem[s][e] = 0;
        end
    endtask

    function automatic bit in_window(input logic [7:0] a);
        return (a >= 8'h40) && (a < 8'hC0);
    endfunction

    task automatic model_step();
        logic [3:0] ev_take, ev_ovf, ev_unf;
        int idx, sub;
        ev_take = 0; ev_ovf = 0; ev_unf = 0;
        idx = (int'(addr) - 'h40) >> 5;
        sub = int'(addr) & 'h1f;
        if (rd_en && in_window(addr) && sub == 8) begin
            if (m_empty[idx]) ev_unf[idx] = 1'b1;
            else begin
                m_rd[idx] = (m_rd[idx] + 1) % 16;
                m_full[idx] = 0;
                if (m_rd[idx] == m_wr[idx]) m_empty[idx] = 1;
            end
        end
        for (int s = 0; s < 4; s++) begin
            if (trig && m_enable[s] && ((m_src >> (4*s)) & 16'hF) == 16'd5) begin
                ev_take[s] = 1'b1;
                m_noise = m_noise * 32'd314159 + 32'd1;
                if (m_full[s]) ev_ovf[s] = 1'b1;
                else begin
                    m_mem[s][m_wr[s]] = 10'h200 + 10'(m_noise[18:16]);
                    m_wr[s] = (m_wr[s] + 1) % 16;
                    m_empty[s] = 0;
                    if (m_wr[s] == m_rd[s]) m_full[s] = 1;
                end
            end
        end
        if (wr_en) begin
            if (in_window(addr)) begin
                if (sub == 0) m_smux[idx] = wdata & 32'h3333_3333;
                else if (sub == 4) m_sctl[idx] = wdata;
            end else begin
                case (addr)
                    8'h00: m_enable = wdata[3:0];
                    8'h08: m_mask = wdata[3:0];
                    8'h0C: m_raw = m_raw & ~wdata[3:0];
                    8'h10: m_ovf = m_ovf & ~wdata[3:0];
                    8'h18: m_unf = m_unf & ~wdata[3:0];
                    8'h14: m_src = wdata[15:0];
                    default: ;
                endcase
            end
        end
        m_raw = m_raw | ev_take;
        m_ovf = m_ovf | ev_ovf;
        m_unf = m_unf | ev_unf;
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int idx, sub;
        idx = (int'(a) - 'h40) >> 5;
        sub = int'(a) & 'h1f;
        if (in_window(a)) begin
            case (sub)
                0: return m_smux[idx];
                4: return m_sctl[idx];
                8: return 32'(m_mem[idx][m_rd[idx]]);
                12: return 32'(m_rd[idx]) | (32'(m_wr[idx]) << 4)
                         | (m_empty[idx] ? 32'h100 : 32'h0)
                         | (m_full[idx] ? 32'h1000 : 32'h0);
                default: return 32'h0;
            endcase
        end
        case (a)
            8'h00: return 32'(m_enable);
            8'h04: return 32'(m_raw);
            8'h08: return 32'(m_mask);
            8'h0C: return 32'(m_raw & m_mask);
            8'h10: return 32'(m_ovf);
            8'h14: return 32'(m_src);
            8'h18: return 32'(m_unf);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // ---------------- checking helpers ----------------
    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle interrupt comparison (R7)
    always @(negedge clk) begin
        if (live) check(32'(irq), 32'(m_raw & m_mask), "R7 irq vs model");
    end

    // drive one cycle; every task starts and ends at a falling edge
    task automatic op(input bit w, input bit r, input bit t,
                      input logic [7:0] a, input logic [31:0] d, input string tag);
        wr_en = w; rd_en = r; trig = t; addr = a; wdata = d;
        #1;
        if (r) check(rdata, model_read(a), tag);
        @(negedge clk);
        wr_en = 0; rd_en = 0; trig = 0;
    endtask

    task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1; addr = a;
        #1;
        check(rdata, exp, tag);
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        op(1'b1, 1'b0, 1'b0, a, d, "");
    endtask

    task automatic pulse();
        op(1'b0, 1'b0, 1'b1, 8'h00, 32'h0, "");
    endtask

    function automatic logic [7:0] pick_addr();
        int k;
        k = $urandom_range(0, 27);
        if (k < 8) return 8'(k * 4);
        return 8'(8'h40 + ((k - 8) / 5) * 32 + ((k - 8) % 5) * 4);
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;

        // R1 reset state
        check(32'(irq), 32'h0, "R1 irq after reset");
        for (int s = 0; s < 4; s++) rd_lit(8'(8'h4C + 32*s), 32'h100, "R1 status after reset");
        rd_lit(8'h00, 32'h0, "R1 enable after reset");
        rd_lit(8'h04, 32'h0, "R1 raw after reset");
        rd_lit(8'h10, 32'h0, "R1 overflow after reset");
        rd_lit(8'h18, 32'h0, "R1 underflow after reset");

        // R10 register masking and layout
        wr(8'h00, 32'hFFFF_FFFF);
        rd_lit(8'h00, 32'hF, "R10 enable keeps 4 bits");
        wr(8'h60, 32'hFFFF_FFFF);
        rd_lit(8'h60, 32'h3333_3333, "R10 mux mask");
        wr(8'h84, 32'hDEAD_BEEF);
        rd_lit(8'h84, 32'hDEAD_BEEF, "R10 control full width");
        rd_lit(8'h40, 32'h0, "R10 other window untouched");
        wr(8'h1C, 32'hFFFF_FFFF);
        rd_lit(8'h1C, 32'h0, "R10 unmapped offset");

        // R5 trigger qualification: seq2 wrong source, seq3 disabled
        wr(8'h14, 32'h0000_5355);
        wr(8'h00, 32'h7);
        pulse();
        rd_lit(8'h4C, 32'h10, "R5 seq0 sampled");
        rd_lit(8'h6C, 32'h10, "R5 seq1 sampled");
        rd_lit(8'h8C, 32'h100, "R5 seq2 wrong source");
        rd_lit(8'hAC, 32'h100, "R5 seq3 disabled");
        rd_lit(8'h04, 32'h3, "R7 raw bits set");

        // R6 sample values in index order
        rd_lit(8'h48, 32'h200, "R6 first sample");
        rd_lit(8'h68, 32'h204, "R6 second sample");
        rd_lit(8'h4C, 32'h111, "R4 status after pop");
        rd_lit(8'h6C, 32'h111, "R2 status layout");

        // R7 mask and interrupt
        wr(8'h08, 32'h1);
        check(32'(irq), 32'h1, "R7 irq masked");
        rd_lit(8'h0C, 32'h1, "R7 masked status");

        // R8 clear and set-wins
        wr(8'h0C, 32'h1);
        rd_lit(8'h04, 32'h2, "R8 raw cleared");
        check(32'(irq), 32'h0, "R8 irq dropped");
        op(1'b1, 1'b0, 1'b1, 8'h0C, 32'h3, "");
        rd_lit(8'h04, 32'h3, "R8 sample wins over clear");

        // R3 fill seq0 to full and overflow
        wr(8'h00, 32'h1);
        repeat (15) pulse();
        rd_lit(8'h4C, 32'h1011, "R3 full status");
        rd_lit(8'h10, 32'h0, "R9 no overflow yet");
        pulse();
        rd_lit(8'h10, 32'h1, "R9 overflow flagged");
        rd_lit(8'h4C, 32'h1011, "R3 dropped push");

        // R4 drain and underflow
        for (int e = 0; e < 16; e++) op(1'b0, 1'b1, 1'b0, 8'h48, 32'h0, "R4 drain pop");
        rd_lit(8'h4C, 32'h111, "R4 empty status");
        op(1'b0, 1'b1, 1'b0, 8'h48, 32'h0, "R4 empty pop value");
        rd_lit(8'h4C, 32'h111, "R4 empty pop no advance");
        rd_lit(8'h18, 32'h1, "R9 underflow flagged");

        // R9 write-one-to-clear
        wr(8'h10, 32'h1);
        rd_lit(8'h10, 32'h0, "R9 overflow cleared");
        wr(8'h18, 32'h0);
        rd_lit(8'h18, 32'h1, "R9 zero write keeps");
        wr(8'h18, 32'h1);
        rd_lit(8'h18, 32'h0, "R9 underflow cleared");

        // R11 pop and push in one cycle
        op(1'b0, 1'b1, 1'b1, 8'h48, 32'h0, "R11 pop on empty with push");
        rd_lit(8'h4C, 32'h21, "R11 push after failed pop");
        rd_lit(8'h18, 32'h1, "R11 underflow from empty pop");
        wr(8'h18, 32'h1);
        op(1'b0, 1'b1, 1'b1, 8'h48, 32'h0, "R11 pop one entry with push");
        rd_lit(8'h4C, 32'h32, "R11 pop then push status");
        rd_lit(8'h18, 32'h0, "R11 no underflow");

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int kind;
            logic [7:0] a;
            logic [31:0] d;
            bit t;
            kind = $urandom_range(0, 9);
            a = pick_addr();
            t = ($urandom_range(0, 2) == 0);
            d = $urandom();
            if (a == 8'h14) begin
                d = 0;
                for (int s = 0; s < 4; s++)
                    d[4*s +: 4] = ($urandom_range(0, 3) != 0) ? 4'd5 : 4'($urandom_range(0, 15));
            end
            if (kind < 3)      op(1'b1, 1'b0, t, a, d, "R3 R4 R6 random write");
            else if (kind < 8) op(1'b0, 1'b1, t, a, d, "R2 R4 R11 random read");
            else               op(1'b0, 1'b0, t, a, d, "");
        end
        for (int s = 0; s < 4; s++) op(1'b0, 1'b1, 1'b0, 8'(8'h4C + 32*s), 32'h0, "R2 final status");

        done = 1'b1;
        live = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule